// File: doc/BRIEF.md
# Sampling Window Phase Selector

This block chooses a receive sampling phase for a sixteen-tap delay line once a tuning sweep is over. It takes a 16-bit pass mask, where bit i set means phase i gave good data. It finds the longest stretch of adjacent passing phases. Phase 15 and phase 0 count as neighbours, so a stretch may wrap through the top of the range. The chosen phase lies three quarters of the way into that stretch, not at its middle.

A controller pulses `start` with the mask. The block walks the mask one bit per cycle and keeps only three things: the first run, the best run closed in the middle of the mask, and the run still open at the end. It then settles any wrap-around merge and works out the index. One cycle later it reports `done` together with the chosen `phase`, or with `err` set when no phase can be chosen. Nothing outside the block sees its partial results.

Top module: `swp_phase_select`

## Requirements
- R1: After reset, `done`, `err` and `phase` are all 0.
- R2: A `start` seen while the block is idle is accepted at that rising edge. `done` is high for exactly one cycle, right after the 18th rising edge that follows the accepting edge. A `start` that arrives while a selection is in progress is ignored: it causes no extra result and does not change the result in progress.
- R3: A run is a set of passing phases with ascending, consecutive numbers. When the mask holds a single run that does not wrap, the result is `start + k` with `err` = 0, where `start` is the lowest phase of the run and k is the index given by R4.
- R4: For a winning run of length L, the index k is floor(3L/4), less 1 when that value is nonzero. So L=1 gives k=0, L=2 gives k=0, L=3 gives k=1 and L=4 gives k=2.
- R5: A run that begins at phase 0 and a different run that ends at phase 15 are joined into one run. In the joined run the phase-15 run comes first and the phase-0 run follows. The result is (first phase of the phase-15 run + k) mod 16.
- R6: Runs compete in ascending order of their lowest phase. A run replaces the current best only if it is strictly longer, so the earliest of several equal runs wins. After a join, the phase-0 run takes no part in the contest on its own, and the joined run competes in the place of the phase-15 run.
- R7: An all-zero mask gives `done` with `err` = 1 and `phase` = 0.
- R8: An all-ones mask is one run of length 16 and gives phase 11 with `err` = 0.
- R9: `phase` and `err` keep their values between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a selection; honoured only when idle |
| mask | input | 16 | Pass mask; bit i set means phase i passed |
| done | output | 1 | One-cycle pulse when a result is ready |
| phase | output | 4 | Selected sampling phase |
| err | output | 1 | No usable phase for the last mask |

## Verification
The hardest cases to reach are those where the wrapped run meets a run in the middle of the mask: the joined run ties it or just beats it, and the phase-0 run alone would have won before the join. Directed masks place short runs at both ends of the range around a middle run of a chosen length. A long random sweep sets bits 0 and 15 on every other mask, so that joins occur often. A second `start` sent partway through a selection checks that the block ignores it and gives no extra result.

// File: rtl/swp_pkg.sv
package swp_pkg;
    parameter int SWP_PHASES = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FIN  = 2'd2,
        ST_PICK = 2'd3
    } swp_state_e;
endpackage

// File: rtl/swp_pick_index.sv
// Turns a winning run (length, first phase) into the phase at the
// three-quarter point, wrapping modulo the phase count.
module swp_pick_index #(
    parameter int NPH = 16,
    parameter int PW  = $clog2(NPH),
    parameter int LW  = $clog2(NPH + 1)
) (
    input  logic [LW-1:0] run_len,
    input  logic [PW-1:0] run_start,
    output logic [PW-1:0] pick_phase
);
    localparam int TW = LW + 2;
    localparam int SW = PW + 1;

    logic [TW-1:0] triple;
    logic [TW-1:0] quarter;
    logic [PW-1:0] offset;
    logic [SW-1:0] sum;

    always_comb begin
        triple  = {2'b00, run_len} + {1'b0, run_len, 1'b0};
        quarter = triple >> 2;
        offset  = (quarter != '0) ? PW'(quarter - TW'(1)) : '0;
        sum     = {1'b0, run_start} + {1'b0, offset};
        if (sum >= SW'(NPH)) begin
            pick_phase = PW'(sum - SW'(NPH));
        end else begin
            pick_phase = sum[PW-1:0];
        end
    end
endmodule

// File: rtl/swp_winner.sv
// Chooses the winning run from the first run, the best middle run and
// the run left open at the end of the scan, merging across the wrap.
module swp_winner #(
    parameter int NPH = 16,
    parameter int PW  = $clog2(NPH),
    parameter int LW  = $clog2(NPH + 1)
) (
    input  logic          first_done,
    input  logic [LW-1:0] first_len,
    input  logic [PW-1:0] first_start,
    input  logic [LW-1:0] mid_len,
    input  logic [PW-1:0] mid_start,
    input  logic [LW-1:0] tail_len,
    input  logic [PW-1:0] tail_start,
    output logic [LW-1:0] win_len,
    output logic [PW-1:0] win_start,
    output logic          win_err
);
    localparam int MW = LW + 1;

    logic [MW-1:0] merged_len;

    always_comb begin
        win_len    = '0;
        win_start  = '0;
        win_err    = 1'b0;
        merged_len = {1'b0, first_len} + {1'b0, tail_len};
        if (!first_done) begin
            // the open run, if any, is the only run
            if (tail_len == '0) begin
                win_err = 1'b1;
            end else begin
                win_len   = tail_len;
                win_start = tail_start;
            end
        end else if ((tail_len != '0) && (first_start == '0)) begin
            // wrap merge: first run drops out, tail competes with it appended
            if (merged_len >= MW'(NPH)) begin
                win_err = 1'b1;
            end else if (merged_len > {1'b0, mid_len}) begin
                win_len   = merged_len[LW-1:0];
                win_start = tail_start;
            end else begin
                win_len   = mid_len;
                win_start = mid_start;
            end
        end else begin
            win_len   = first_len;
            win_start = first_start;
            if (mid_len > win_len) begin
                win_len   = mid_len;
                win_start = mid_start;
            end
            if (tail_len > win_len) begin
                win_len   = tail_len;
                win_start = tail_start;
            end
        end
    end
endmodule

// File: rtl/swp_phase_select.sv
module swp_phase_select
    import swp_pkg::*;
#(
    parameter int NPH = SWP_PHASES,
    parameter int PW  = $clog2(NPH),
    parameter int LW  = $clog2(NPH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [NPH-1:0] mask,
    output logic           done,
    output logic [PW-1:0]  phase,
    output logic           err
);
    typedef struct packed {
        swp_state_e     st;
        logic [PW-1:0]  cnt;
        logic [NPH-1:0] msk;
        logic [LW-1:0]  cur_len;
        logic [PW-1:0]  cur_start;
        logic           first_done;
        logic [LW-1:0]  first_len;
        logic [PW-1:0]  first_start;
        logic [LW-1:0]  mid_len;
        logic [PW-1:0]  mid_start;
        logic [LW-1:0]  win_len;
        logic [PW-1:0]  win_start;
        logic           win_err;
        logic           done;
        logic [PW-1:0]  phase;
        logic           err;
    } swp_regs_t;

    swp_regs_t r_q, r_d;

    logic [LW-1:0]  w_len;
    logic [PW-1:0]  w_start;
    logic           w_err;
    logic [PW-1:0]  pick_phase;
    logic           idle;
    logic [NPH-1:0] mask_lat;

    swp_winner #(.NPH(NPH), .PW(PW), .LW(LW)) u_winner (
        .first_done  (r_q.first_done),
        .first_len   (r_q.first_len),
        .first_start (r_q.first_start),
        .mid_len     (r_q.mid_len),
        .mid_start   (r_q.mid_start),
        .tail_len    (r_q.cur_len),
        .tail_start  (r_q.cur_start),
        .win_len     (w_len),
        .win_start   (w_start),
        .win_err     (w_err)
    );

    swp_pick_index #(.NPH(NPH), .PW(PW), .LW(LW)) u_pick (
        .run_len    (r_q.win_len),
        .run_start  (r_q.win_start),
        .pick_phase (pick_phase)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st          = ST_SCAN;
                    r_d.cnt         = '0;
                    r_d.msk         = mask;
                    r_d.cur_len     = '0;
                    r_d.cur_start   = '0;
                    r_d.first_done  = 1'b0;
                    r_d.first_len   = '0;
                    r_d.first_start = '0;
                    r_d.mid_len     = '0;
                    r_d.mid_start   = '0;
                end
            end
            ST_SCAN: begin
                if (r_q.msk[r_q.cnt]) begin
                    if (r_q.cur_len == '0) begin
                        r_d.cur_start = r_q.cnt;
                    end
                    r_d.cur_len = r_q.cur_len + LW'(1);
                end else if (r_q.cur_len != '0) begin
                    // a run has just closed
                    if (!r_q.first_done) begin
                        r_d.first_done  = 1'b1;
                        r_d.first_len   = r_q.cur_len;
                        r_d.first_start = r_q.cur_start;
                    end else if (r_q.cur_len > r_q.mid_len) begin
                        r_d.mid_len   = r_q.cur_len;
                        r_d.mid_start = r_q.cur_start;
                    end
                    r_d.cur_len = '0;
                end
                if (r_q.cnt == PW'(NPH - 1)) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.cnt = r_q.cnt + PW'(1);
                end
            end
            ST_FIN: begin
                r_d.win_len   = w_len;
                r_d.win_start = w_start;
                r_d.win_err   = w_err;
                r_d.st        = ST_PICK;
            end
            ST_PICK: begin
                r_d.done  = 1'b1;
                r_d.err   = r_q.win_err;
                r_d.phase = r_q.win_err ? '0 : pick_phase;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign idle     = (r_q.st == ST_IDLE);
    assign mask_lat = r_q.msk;
    assign done     = r_q.done;
    assign phase    = r_q.phase;
    assign err      = r_q.err;
endmodule

// File: rtl/swp_phase_select_chk.sv
module swp_phase_select_chk #(
    parameter int NPH = 16,
    parameter int PW  = $clog2(NPH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           idle,
    input logic [NPH-1:0] mask_lat,
    input logic           done,
    input logic [PW-1:0]  phase,
    input logic           err
);
    localparam int LAT = NPH + 3;
    localparam int CW  = $clog2(LAT + 2);
    localparam logic [PW-1:0] FULL_PICK = PW'((NPH * 3) / 4 - 1);

    logic [CW-1:0] lat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (idle && start) begin
            lat_cnt <= CW'(1);
        end else if (done) begin
            lat_cnt <= '0;
        end else if (lat_cnt != '0) begin
            lat_cnt <= lat_cnt + CW'(1);
        end
    end

    // R2: result is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: fixed latency from accepting edge
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == CW'(LAT)));

    // R3: a selected phase always passed
    p_pass_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> mask_lat[phase]);

    // R7: empty mask flags an error
    p_empty_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mask_lat == '0)) |-> (err && (phase == '0)));

    // R8: full mask picks the three-quarter point of the whole range
    p_all_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mask_lat == '1)) |-> (!err && (phase == FULL_PICK)));

    // R9: outputs hold between results
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(phase) && $stable(err)));
endmodule

bind swp_phase_select swp_phase_select_chk #(.NPH(NPH), .PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .idle     (idle),
    .mask_lat (mask_lat),
    .done     (done),
    .phase    (phase),
    .err      (err)
);

// File: tb/swp_phase_select_tb.sv
`timescale 1ns/1ps
module swp_phase_select_tb;
    logic        clk;
    logic        rst_n;
    logic        start;
    logic [15:0] mask;
    logic        done;
    logic [3:0]  phase;
    logic        err;

    typedef struct {
        logic [15:0] m;
        logic        e;
        logic [3:0]  p;
        int          cyc;
        string       tag;
    } item_t;

    item_t q[$];
    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    logic       last_e;
    logic [3:0] last_p;

    swp_phase_select u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .mask  (mask),
        .done  (done),
        .phase (phase),
        .err   (err)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // independent model built from the requirements
    function automatic logic [4:0] model(input logic [15:0] m);
        int rl[16];
        int rs[16];
        int nr = 0;
        int prev = -2;
        int best = 0;
        int bi = 0;
        int k;
        for (int p = 0; p < 16; p++) begin
            if (m[p]) begin
                if (p == prev + 1) rl[nr-1]++;
                else begin
                    rs[nr] = p;
                    rl[nr] = 1;
                    nr++;
                end
                prev = p;
            end
        end
        if (nr == 0) return 5'b10000;
        if (rs[0] == 0 && nr > 1 && rs[nr-1] + rl[nr-1] == 16) begin
            if (rl[0] + rl[nr-1] >= 16) return 5'b10000;
            rl[nr-1] += rl[0];
            rl[0] = 0;
        end
        for (int r = 0; r < nr; r++) begin
            if (rl[r] > best) begin
                best = rl[r];
                bi = r;
            end
        end
        k = (best * 3) / 4;
        if (k != 0) k--;
        return {1'b0, 4'((rs[bi] + k) % 16)};
    endfunction

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pop and compare on every result
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                check("R2 unexpected done", 1'b0, 1, 0);
            end else begin
                item_t it;
                it = q.pop_front();
                check({it.tag, " result"}, (err == it.e) && (phase == it.p),
                      {27'd0, err, phase}, {27'd0, it.e, it.p});
                check("R2 latency", (cyc - it.cyc) == 19, cyc - it.cyc, 19);
                last_e = it.e;
                last_p = it.p;
            end
        end
    end

    task automatic push_and_start(input logic [15:0] m, input string tag);
        item_t it;
        logic [4:0] r;
        r = model(m);
        @(negedge clk);
        it.m = m; it.e = r[4]; it.p = r[3:0]; it.cyc = cyc; it.tag = tag;
        q.push_back(it);
        start = 1'b1;
        mask  = m;
        @(negedge clk);
        start = 1'b0;
        mask  = '0;
    endtask

    task automatic run(input logic [15:0] m, input string tag);
        push_and_start(m, tag);
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        mask  = '0;
        repeat (3) @(negedge clk);
        check("R1 reset done", done == 1'b0, done, 0);
        check("R1 reset err", err == 1'b0, err, 0);
        check("R1 reset phase", phase == 4'd0, phase, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run(16'h0000, "R7 empty");
        run(16'hFFFF, "R8 all ones");
        run(16'h0020, "R3 single bit");
        run(16'h001C, "R4 len3");
        run(16'h0F00, "R4 len4");
        run(16'h0300, "R4 len2");
        run(16'hE3C7, "R5 merge wins");
        run(16'h8001, "R5 two singles");
        run(16'hF00F, "R5 merge long");
        run(16'h071C, "R6 equal runs");
        run(16'hC1E3, "R6 merge ties middle");

        // R9: outputs hold after a result
        repeat (6) @(negedge clk);
        check("R9 hold phase", phase == last_p, phase, last_p);
        check("R9 hold err", err == last_e, err, last_e);

        // R2: start while busy is ignored
        push_and_start(16'h00F0, "R2 busy start");
        repeat (4) @(negedge clk);
        start = 1'b1;
        mask  = 16'h0001;
        @(negedge clk);
        start = 1'b0;
        mask  = '0;
        while (q.size() != 0) @(negedge clk);
        repeat (25) @(negedge clk);
        check("R2 no extra result", (q.size() == 0) && (phase == last_p), phase, last_p);

        for (int i = 0; i < 150; i++) begin
            logic [15:0] m;
            m = 16'($urandom);
            if (i % 2 == 0) m = m | 16'h8001;
            run(m, "R3 R5 R6 random");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule